// File: doc/BRIEF.md
# Multiplexed Parallel Slave Port

This block is the device end of an 8-bit host bus on which the low address byte and the data byte travel over the same eight lines. The upper seven address bits arrive on input-only lines. The host selects the device, places an address on all fifteen lines and pulses the address-latch strobe. It then sets the direction line and pulses the enable strobe. On a write the host has already swapped the shared lines over to the write byte; on a read it waits for the device to drive the shared lines.

Every bus input is brought into the system clock domain through a synchroniser chain. Strobe edges are then detected on the synchronised copies. On the inside, the block turns each bus access into a one-cycle strobe toward a register file, which returns read data in the same cycle.

Read data is held back from the bus for a programmable number of cycles, standing in for the access time. An enable pulse that is not preceded by a new address phase repeats the access at the address already latched. If address-latch and enable are both high while the device is selected, the block reports a protocol error and drops the access.

Top module: `mux_pport`

## Requirements
- R1: After reset, `reg_wr`, `reg_rd`, `bus_ad_oe` and `proto_err` are low and `reg_addr` is zero.
- R2: When the synchronised address strobe falls while select is high and enable is low, `reg_addr` takes the full 15-bit address. Bits 14:8 come from `bus_addr_hi` and bits 7:0 from `bus_ad_in`, both as sampled while the strobe was still high.
- R3: `bus_ad_oe` is high only while the synchronised select, direction (high = read) and enable are all high. The address-only lines are inputs and have no output.
- R4: A falling enable edge with direction low (write) raises `reg_wr` for exactly one cycle. `reg_wdata` then equals the shared-line byte sampled while enable was high.
- R5: A rising enable edge with direction high (read) raises `reg_rd` for exactly one cycle at the latched address. `reg_wr` and `reg_rd` are never high together.
- R6: After `reg_rd`, `bus_ad_oe` stays low for ACCESS_CYCLES cycles and then rises. While it is high, `bus_ad_out` carries the `reg_rdata` value returned for that address. It falls within SYNC_STAGES+1 cycles of enable falling.
- R7: A further enable pulse with no new address phase performs the access again at the same `reg_addr`.
- R8: While select is low, address-strobe and enable pulses have no effect: `reg_addr` is kept and no strobe is issued.
- R9: Address-strobe and enable high together while selected raise `proto_err`. No write or read strobe comes from that enable pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Device select, active high |
| bus_al | input | 1 | Address-latch strobe, active high |
| bus_rw | input | 1 | Direction, high = read, low = write |
| bus_en | input | 1 | Enable strobe, active high |
| bus_addr_hi | input | 7 | Address-only lines, bits 14:8 |
| bus_ad_in | input | 8 | Shared lines as seen by the device |
| bus_ad_out | output | 8 | Read byte offered to the shared lines |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| reg_addr | output | 15 | Latched register-file address |
| reg_wdata | output | 8 | Register-file write byte |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register-file read byte, combinational from reg_addr |
| proto_err | output | 1 | Strobe-overlap protocol error |

## Verification
The bench sweeps a set of spread-out addresses and data bytes, so each address bit and data bit is seen at both values. A design that dropped or swapped any line of the address or data paths would therefore return a wrong byte. For each read it counts the cycles from the read strobe to the first cycle of drive enable. A design that drives early would put unsettled data on the lines, and one that miscounts the delay would show a different gap. It repeats an enable pulse without a new address phase, pulses both strobes with the device deselected, and overlaps the two strobes. A design that relatched on enable, listened while deselected, or wrote during an overlap would each produce a wrong address or an extra strobe.

// File: rtl/mux_pport.sv
module mux_pport #(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int ACCESS_CYCLES = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_cs,
  input  logic                     bus_al,
  input  logic                     bus_rw,
  input  logic                     bus_en,
  input  logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  input  logic [DATA_W-1:0]        bus_ad_in,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe,
  output logic [ADDR_W-1:0]        reg_addr,
  output logic [DATA_W-1:0]        reg_wdata,
  output logic                     reg_wr,
  output logic                     reg_rd,
  input  logic [DATA_W-1:0]        reg_rdata,
  output logic                     proto_err
);

  localparam int IW = 4 + ADDR_W;
  localparam int CW = $clog2(ACCESS_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACCESS_CYCLES);

  logic [SYNC_STAGES-1:0][IW-1:0] sr;
  logic [IW-1:0] cur, prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr   <= '0;
      prev <= '0;
    end else begin
      sr[0] <= {bus_cs, bus_al, bus_rw, bus_en, bus_addr_hi, bus_ad_in};
      for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
      prev <= cur;
    end

  assign cur = sr[SYNC_STAGES-1];

  wire s_cs  = cur[IW-1];
  wire s_al  = cur[IW-2];
  wire s_rw  = cur[IW-3];
  wire s_en  = cur[IW-4];
  wire p_al  = prev[IW-2];
  wire p_rw  = prev[IW-3];
  wire p_en  = prev[IW-4];
  wire [ADDR_W-1:0] p_addr = prev[ADDR_W-1:0];

  wire al_fall  = p_al & ~s_al;
  wire en_rise  = ~p_en & s_en;
  wire en_fall  = p_en & ~s_en;
  wire conflict = s_cs & s_al & s_en;

  logic armed, rd_active;
  logic [CW-1:0] wait_cnt;
  logic [DATA_W-1:0] rdata_q;

  wire do_latch = al_fall & s_cs & ~s_en & ~p_en;
  wire do_write = en_fall & armed & ~p_rw & s_cs;
  wire do_read  = en_rise & s_cs & s_rw & ~conflict;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed     <= 1'b0;
      rd_active <= 1'b0;
      wait_cnt  <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      rdata_q   <= '0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= conflict;
      reg_wr    <= do_write;
      reg_rd    <= do_read;

      if (!s_cs || !s_en || conflict) armed <= 1'b0;
      else if (en_rise)               armed <= 1'b1;

      if (!s_cs || !s_en || !s_rw || conflict) rd_active <= 1'b0;
      else if (do_read)                        rd_active <= 1'b1;

      if (do_read)             wait_cnt <= CNT_LOAD;
      else if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;

      if (do_latch) reg_addr  <= p_addr;
      if (do_write) reg_wdata <= p_addr[DATA_W-1:0];
      if (reg_rd)   rdata_q   <= reg_rdata;
    end

  assign bus_ad_out = rdata_q;
  assign bus_ad_oe  = rd_active & (wait_cnt == '0) & s_cs & s_rw & s_en;

  initial if (ACCESS_CYCLES < 1 || SYNC_STAGES < 1) $error("bad parameters");

  AST_WR_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R4
  AST_RD_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd); // R5
  AST_STROBE_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd)); // R5
  AST_ACCESS_DELAY:  assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !bus_ad_oe); // R6
  AST_OE_NEEDS_EN:   assert property (@(posedge clk) disable iff (!rst_n) bus_ad_oe |-> armed); // R3
  AST_DESEL_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !s_cs |=> $stable(reg_addr)); // R8
  AST_ERR_NO_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) proto_err |=> !reg_wr); // R9

endmodule

// File: tb/test_mux_pport.sv
module test_mux_pport;
  localparam int ACC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, al = 0, rw = 0, en = 0;
  logic [6:0] hi = '0;
  logic [7:0] ad = '0;
  logic [7:0] ad_out, wdata, rdata;
  logic [14:0] raddr;
  logic oe, wr, rd, perr;

  always #2 clk = ~clk;

  assign rdata = raddr[7:0] ^ {1'b0, raddr[14:8]} ^ 8'h5A;

  mux_pport #(.ACCESS_CYCLES(ACC)) i_mux_pport (
    .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_al(al), .bus_rw(rw), .bus_en(en),
    .bus_addr_hi(hi), .bus_ad_in(ad), .bus_ad_out(ad_out), .bus_ad_oe(oe),
    .reg_addr(raddr), .reg_wdata(wdata), .reg_wr(wr), .reg_rd(rd),
    .reg_rdata(rdata), .proto_err(perr));

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, gap = 0, oe_gap = -1;
  bit tracking = 0;
  logic [14:0] wr_a, rd_a;
  logic [7:0] wr_d, oe_data;

  always @(negedge clk) if (rst_n) begin
    if (wr) begin wr_cnt++; wr_a = raddr; wr_d = wdata; end
    if (rd) begin rd_cnt++; rd_a = raddr; tracking = 1; gap = 0; end
    else if (tracking) begin
      gap++;
      if (oe) begin oe_gap = gap; oe_data = ad_out; tracking = 0; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic latch(input logic [14:0] a);
    cs = 1; en = 0; ad = a[7:0]; hi = a[14:8];
    cyc(1); al = 1; cyc(3); al = 0; cyc(4);
  endtask

  task automatic write(input logic [7:0] d);
    rw = 0; ad = d; cyc(4); en = 1; cyc(4); en = 0; cyc(5);
  endtask

  task automatic read_chk(input logic [14:0] a);
    int rc0;
    rc0 = rd_cnt; oe_gap = -1;
    ad = 8'h00; rw = 1; cyc(3); en = 1; cyc(ACC + 8);
    chk(rd_cnt == rc0 + 1, "R5 read strobe count", rd_cnt - rc0, 1);
    chk(rd_a == a, "R5 read address", rd_a, a);
    chk(oe_gap == ACC, "R6 drive delay", oe_gap, ACC);
    chk(oe === 1'b1, "R3 drive while enabled", oe, 1);
    chk(oe_data == (a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A), "R6 read data", oe_data,
        a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A);
    en = 0; cyc(4);
    chk(oe === 1'b0, "R6 release after enable", oe, 0);
    rw = 0; cyc(2);
  endtask

  initial begin
    cyc(3);
    chk(!wr && !rd && !oe && !perr && raddr == 0, "R1 reset state",
        {wr, rd, oe, perr, raddr}, 0);
    rst_n = 1; cyc(3);

    for (int i = 0; i < 16; i++) begin
      logic [14:0] a;
      logic [7:0] d;
      int wc0;
      a = 15'((i * 16'h1357 + 16'h0421) ^ (1 << (i % 15)));
      d = 8'((i * 37 + 5) ^ (1 << (i % 8)));
      latch(a);
      chk(raddr == a, "R2 address latch", raddr, a);
      wc0 = wr_cnt;
      write(d);
      chk(wr_cnt == wc0 + 1, "R4 write strobe count", wr_cnt - wc0, 1);
      chk(wr_a == a && wr_d == d, "R4 write address/data", {wr_a, wr_d}, {a, d});
      chk(oe === 1'b0, "R3 no drive on write", oe, 0);
      read_chk(a);
      if (i % 4 == 0) begin
        wc0 = wr_cnt;
        write(~d);
        chk(wr_cnt == wc0 + 1 && wr_a == a && wr_d == ~d, "R7 repeat write same address",
            wr_a, a);
        read_chk(a);
      end
    end

    begin
      logic [14:0] keep;
      int wc0, rc0;
      keep = 15'h2A5C;
      latch(keep);
      wc0 = wr_cnt; rc0 = rd_cnt;
      cs = 0; ad = 8'hC3; hi = 7'h11; cyc(2);
      al = 1; cyc(3); al = 0; cyc(4);
      rw = 0; en = 1; cyc(4); en = 0; cyc(4);
      rw = 1; en = 1; cyc(ACC + 6);
      chk(oe === 1'b0, "R8 no drive while deselected", oe, 0);
      en = 0; cyc(4);
      chk(raddr == keep, "R8 address kept", raddr, keep);
      chk(wr_cnt == wc0 && rd_cnt == rc0, "R8 no strobes", wr_cnt + rd_cnt, wc0 + rc0);
      cs = 1; write(8'h77);
      chk(wr_a == keep && wr_d == 8'h77, "R8 later write uses kept address", wr_a, keep);
    end

    begin
      int wc0;
      latch(15'h1234);
      chk(perr === 1'b0, "R9 no error before overlap", perr, 0);
      wc0 = wr_cnt;
      rw = 0; ad = 8'h99; cyc(2);
      en = 1; cyc(3); al = 1; cyc(5);
      chk(perr === 1'b1, "R9 error flagged", perr, 1);
      al = 0; cyc(3); en = 0; cyc(5);
      chk(wr_cnt == wc0, "R9 write dropped", wr_cnt - wc0, 0);
      chk(perr === 1'b0, "R9 error clears", perr, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #600000;
    tests++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule